// File: doc/BRIEF.md
# Triggered Multichannel ADC Event Reader

This block reads out a fixed list of multiplexed analog channels each time an armed trigger arrives. The channels come from several front-end chips, each of which gives a fixed number of outputs; the last output of each chip is an extra thermometer channel, read like the others. The block steps an external analog multiplexer one channel at a time. After each step it waits a fixed settling time, then samples a parallel ADC together with its out-of-range flag. It packs each sample into a 16-bit word and stores the whole event in an internal buffer. The event has no header and no trailer.

Software controls the block through a small byte-wide register port. It opens a gate to arm the trigger and polls a status register until an event is waiting. It then drains the event through a byte-wide data register, two reads per word, upper byte first. From the trigger until the last byte is read, the block stays busy and ignores further triggers. A write to a dedicated release address forces it back to idle, so software can recover a sequence that is stuck.

Register addresses (reg_addr): 0 is the gate (read/write, bit 0). 1 is the status (read-only: bit 0 is event waiting, bit 1 is busy). 2 is the data byte (read). 3 is the busy release (write, any data).

Top module: `adc_event_reader`

## Requirements
- R1: The gate is bit 0 of address 0. It resets to 0, a write stores reg_wbit into it, and a read returns it in bit 0 with bits 7..1 at zero.
- R2: A rising edge on hold_trig starts a readout only when the gate is 1 and the block is idle, and busy is 1 from the following cycle. With the gate at 0 the edge has no effect.
- R3: For each word, mux_step is high for exactly one cycle with mux_chip/mux_chan naming the channel. The ADC is sampled SETTLE_CYC+1 cycles later. Successive strobes are SETTLE_CYC+2 cycles apart. The order runs from chip 0 channel 0 through channel WORDS_PER_CHIP-1, then on to the next chip.
- R4: Each stored word is {3'b000, adc_otr, adc_data[11:0]}, so bits 15..13 are zero, bit 12 is the out-of-range flag and bits 11..0 are the sample.
- R5: An event is exactly N_CHIPS*WORDS_PER_CHIP words (132 by default) with no header or trailer. Status bit 0 becomes 1 only after the last word is stored, and it stays 0 while sampling.
- R6: Reads of address 2 return each word upper byte first, then lower byte, in event order. After the lower byte of the last word, status bit 0 and busy both return to 0.
- R7: Triggers that arrive while busy are dropped and leave the stored event unchanged.
- R8: A write to address 3 forces busy and status bit 0 to 0 in the next cycle and stops multiplexer stepping. The next accepted trigger then starts a full event from chip 0 channel 0.
- R9: A read of address 2 while no event is waiting returns 0 and does not advance the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_trig | input | 1 | Delayed hold trigger, rising edge starts a readout |
| adc_data | input | ADC_W (12) | Parallel ADC sample |
| adc_otr | input | 1 | ADC out-of-range flag |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wbit | input | 1 | Write data (gate value) |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| mux_step | output | 1 | One-cycle strobe that steps the analog multiplexer |
| mux_chip | output | CHIP_W (2) | Chip index of the current channel |
| mux_chan | output | CHAN_W (6) | Channel index within the chip |
| busy | output | 1 | High from accepted trigger until drained or released |

## Verification
The bench builds the block with its default shape of 4 chips by 33 words and a settling time of 3 cycles. That makes each event the full 132 words, so the chip wrap after the thermometer channel and the last-word flag clear are both reached. A short settling time keeps each event near 660 cycles, which leaves room for several random events, drains with random gaps, triggers while busy, and releases both in mid-sampling and with an event waiting.

// File: rtl/adc_event_reader.sv
module adc_event_reader #(
  parameter int N_CHIPS        = 4,
  parameter int WORDS_PER_CHIP = 33,
  parameter int SETTLE_CYC     = 3,
  parameter int ADC_W          = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              hold_trig,
  input  logic [ADC_W-1:0]                  adc_data,
  input  logic                              adc_otr,
  input  logic                              reg_wr,
  input  logic                              reg_rd,
  input  logic [1:0]                        reg_addr,
  input  logic                              reg_wbit,
  output logic [7:0]                        reg_rdata,
  output logic                              mux_step,
  output logic [$clog2(N_CHIPS)-1:0]        mux_chip,
  output logic [$clog2(WORDS_PER_CHIP)-1:0] mux_chan,
  output logic                              busy
);
  localparam int N_WORDS = N_CHIPS * WORDS_PER_CHIP;
  localparam int PTR_W   = $clog2(N_WORDS + 1);
  localparam int CHIP_W  = $clog2(N_CHIPS);
  localparam int CHAN_W  = $clog2(WORDS_PER_CHIP);
  localparam int SET_W   = $clog2(SETTLE_CYC + 1);
  localparam int PAD_W   = 15 - ADC_W;

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_SETTLE, S_LATCH, S_HOLD} state_t;

  state_t              state;
  logic                trig_q, gate_q, event_rdy, byte_lo;
  logic [PTR_W-1:0]    wptr, rptr;
  logic [CHIP_W-1:0]   chip_q;
  logic [CHAN_W-1:0]   chan_q;
  logic [SET_W-1:0]    settle_cnt;
  logic [15:0]         mem [0:N_WORDS-1];
  logic [15:0]         rd_word;

  wire trig_rise = hold_trig & ~trig_q;
  wire release_w = reg_wr && (reg_addr == 2'd3);
  wire data_rd   = reg_rd && (reg_addr == 2'd2) && event_rdy;
  wire last_rd   = (rptr == PTR_W'(N_WORDS - 1));
  wire last_wr   = (wptr == PTR_W'(N_WORDS - 1));
  wire last_chan = (chan_q == CHAN_W'(WORDS_PER_CHIP - 1));

  assign busy     = (state != S_IDLE);
  assign mux_step = (state == S_STEP);
  assign mux_chip = chip_q;
  assign mux_chan = chan_q;
  assign rd_word  = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      trig_q <= hold_trig;
      if (reg_wr && reg_addr == 2'd0) gate_q <= reg_wbit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      wptr       <= '0;
      rptr       <= '0;
      chip_q     <= '0;
      chan_q     <= '0;
      settle_cnt <= '0;
      event_rdy  <= 1'b0;
      byte_lo    <= 1'b0;
    end else if (release_w) begin
      state     <= S_IDLE;
      wptr      <= '0;
      rptr      <= '0;
      chip_q    <= '0;
      chan_q    <= '0;
      event_rdy <= 1'b0;
      byte_lo   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (trig_rise && gate_q) begin
          state   <= S_STEP;
          wptr    <= '0;
          rptr    <= '0;
          chip_q  <= '0;
          chan_q  <= '0;
          byte_lo <= 1'b0;
        end
        S_STEP: begin
          settle_cnt <= '0;
          state      <= S_SETTLE;
        end
        S_SETTLE: begin
          if (settle_cnt == SET_W'(SETTLE_CYC - 1)) state <= S_LATCH;
          else settle_cnt <= settle_cnt + 1'b1;
        end
        S_LATCH: begin
          wptr <= wptr + 1'b1;
          if (last_chan) begin
            chan_q <= '0;
            chip_q <= chip_q + 1'b1;
          end else begin
            chan_q <= chan_q + 1'b1;
          end
          if (last_wr) begin
            state     <= S_HOLD;
            event_rdy <= 1'b1;
          end else begin
            state <= S_STEP;
          end
        end
        S_HOLD: if (data_rd) begin
          if (byte_lo) begin
            byte_lo <= 1'b0;
            if (last_rd) begin
              state     <= S_IDLE;
              event_rdy <= 1'b0;
            end else begin
              rptr <= rptr + 1'b1;
            end
          end else begin
            byte_lo <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_LATCH) mem[wptr] <= {{PAD_W{1'b0}}, adc_otr, adc_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        2'd0:    reg_rdata <= {7'b0, gate_q};
        2'd1:    reg_rdata <= {6'b0, busy, event_rdy};
        2'd2:    reg_rdata <= !event_rdy ? 8'h00 : (byte_lo ? rd_word[7:0] : rd_word[15:8]);
        default: reg_rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/adc_event_reader_chk.sv
module adc_event_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_trig,
  input logic       gate_q,
  input logic       busy,
  input logic       event_rdy,
  input logic       mux_step,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       reg_wbit
);
  assert_gate_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (gate_q == $past(reg_wbit)));

  assert_accept_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(gate_q) && $past(hold_trig)));

  assert_step_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mux_step |-> busy);

  assert_step_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mux_step |=> !mux_step);

  assert_ready_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    event_rdy |-> (busy && !mux_step));

  assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> (!busy && !event_rdy));
endmodule

bind adc_event_reader adc_event_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_trig(hold_trig), .gate_q(gate_q),
  .busy(busy), .event_rdy(event_rdy), .mux_step(mux_step),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wbit(reg_wbit)
);

// File: tb/adc_event_reader_tb.sv
module adc_event_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_CHIPS = 4;
  localparam int WPC     = 33;
  localparam int SETTLE  = 3;
  localparam int N_WORDS = N_CHIPS * WPC;

  logic clk = 1'b0, rst_n = 1'b0, hold_trig = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, reg_wbit = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [11:0] adc_data;
  logic adc_otr;
  logic [7:0] reg_rdata;
  logic mux_step, busy;
  logic [1:0] mux_chip;
  logic [5:0] mux_chan;

  int tests = 0, fails = 0;
  int seed = 0;
  int step_cnt = 0, last_step = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] f_adc(int s, int chip, int chan);
    return 12'((s * 37 + chip * 331 + chan * 13) & 32'hfff);
  endfunction
  function automatic logic f_otr(int s, int chip, int chan);
    return ((s ^ chip ^ chan) & 3) == 0;
  endfunction
  function automatic logic [15:0] f_word(int s, int idx);
    return {3'b000, f_otr(s, idx / WPC, idx % WPC), f_adc(s, idx / WPC, idx % WPC)};
  endfunction

  assign adc_data = f_adc(seed, int'(mux_chip), int'(mux_chan));
  assign adc_otr  = f_otr(seed, int'(mux_chip), int'(mux_chan));

  adc_event_reader #(.N_CHIPS(N_CHIPS), .WORDS_PER_CHIP(WPC), .SETTLE_CYC(SETTLE), .ADC_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .hold_trig(hold_trig), .adc_data(adc_data), .adc_otr(adc_otr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wbit(reg_wbit),
    .reg_rdata(reg_rdata), .mux_step(mux_step), .mux_chip(mux_chip), .mux_chan(mux_chan), .busy(busy));

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mux_step && rst_n) begin
      check(int'(mux_chip) == step_cnt / WPC && int'(mux_chan) == step_cnt % WPC,
            "R3 order", {int'(mux_chip), 8'(mux_chan)}, {step_cnt / WPC, 8'(step_cnt % WPC)});
      if (step_cnt > 0) check(cyc - last_step == SETTLE + 2, "R3 spacing", cyc - last_step, SETTLE + 2);
      last_step = cyc;
      step_cnt++;
    end
  end

  task automatic wr(logic [1:0] a, logic b);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wbit = b;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask
  task automatic pulse_trig();
    @(negedge clk); hold_trig = 1'b1;
    @(negedge clk); hold_trig = 1'b0;
  endtask
  task automatic wait_ready(output bit ok);
    logic [7:0] d;
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      rd(2'd1, d);
      if (d[0]) begin ok = 1; break; end
    end
  endtask
  task automatic drain(int s, bit gaps);
    logic [7:0] hi, lo, d;
    logic [15:0] w;
    for (int i = 0; i < N_WORDS; i++) begin
      w = f_word(s, i);
      rd(2'd2, hi);
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
      rd(2'd2, lo);
      if (i == 0 || i == WPC - 1 || i == WPC || i == N_WORDS - 1 || hi != w[15:8] || lo != w[7:0]) begin
        check(hi[7:5] == 3'b000, "R4 pad bits", int'(hi[7:5]), 0);
        check({hi, lo} == w, "R6 word", int'({hi, lo}), int'(w));
      end
    end
    rd(2'd1, d);
    check(d == 8'h00, "R6 flag and busy clear after last byte", d, 0);
    rd(2'd2, d);
    check(d == 8'h00, "R9 empty data read", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R5 act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit ok;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && mux_step == 1'b0, "R2 reset idle", busy, 0);
    rd(2'd0, d); check(d == 8'h00, "R1 gate reset", d, 0);
    rd(2'd1, d); check(d == 8'h00, "R5 status reset", d, 0);

    pulse_trig();
    repeat (5) @(negedge clk);
    check(busy == 1'b0 && step_cnt == 0, "R2 trigger with gate closed", busy, 0);

    wr(2'd0, 1'b1);
    rd(2'd0, d); check(d == 8'h01, "R1 gate readback", d, 1);
    rd(2'd2, d); check(d == 8'h00, "R9 data read with no event", d, 0);

    for (int ev = 0; ev < 4; ev++) begin
      seed = int'($urandom_range(0, 4095));
      step_cnt = 0;
      pulse_trig();
      check(busy == 1'b1, "R2 busy after armed trigger", busy, 1);
      repeat ($urandom_range(10, 60)) @(negedge clk);
      rd(2'd1, d); check(d == 8'h02, "R5 no flag while sampling", d, 2);
      rd(2'd2, d); check(d == 8'h00, "R9 data read during sampling", d, 0);
      wait_ready(ok);
      check(ok, "R5 event flag sets", ok, 1);
      check(step_cnt == N_WORDS, "R5 word count", step_cnt, N_WORDS);
      pulse_trig();
      repeat (8) @(negedge clk);
      check(step_cnt == N_WORDS, "R7 trigger during busy dropped", step_cnt, N_WORDS);
      drain(seed, ev[0]);
    end

    seed = 77; step_cnt = 0;
    pulse_trig();
    repeat (200) @(negedge clk);
    wr(2'd3, 1'b0);
    check(busy == 1'b0, "R8 release mid sampling", busy, 0);
    d = 8'(step_cnt);
    repeat (20) @(negedge clk);
    check(step_cnt == int'(d), "R8 stepping stopped", step_cnt, int'(d));
    rd(2'd1, d); check(d == 8'h00, "R8 status after release", d, 0);

    seed = 901; step_cnt = 0;
    pulse_trig();
    wait_ready(ok);
    check(ok && step_cnt == N_WORDS, "R8 full event after release", step_cnt, N_WORDS);
    rd(2'd2, d);
    wr(2'd3, 1'b1);
    rd(2'd1, d); check(d == 8'h00, "R8 release with event waiting", d, 0);

    seed = 2024; step_cnt = 0;
    pulse_trig();
    wait_ready(ok);
    drain(seed, 1'b0);

    wr(2'd0, 1'b0);
    rd(2'd0, d); check(d == 8'h00, "R1 gate cleared", d, 0);
    step_cnt = 0;
    pulse_trig();
    repeat (10) @(negedge clk);
    check(busy == 1'b0 && step_cnt == 0, "R2 closed gate ignores trigger", busy, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule